// File: doc/BRIEF.md
# Windowed Pulse Charge Integrator

This block sits on one channel of a sampling front end. Each accepted beat brings one 12-bit sample and the channel's current baseline. When upstream timing logic marks a pulse start inside a programmable integral window, the block sums sample minus baseline. It keeps the running peak of that difference and closes the integral at the first stop condition that applies: the sample position leaves the integral window, the length cap is reached, the pulse falls back to 1/32 of its peak, or upstream marks an inter-pulse minimum. On a pileup minimum the block closes the current integral and opens a new one at once, starting with the minimum sample and using the same baseline.

Each closed integral is clamped to a signed 16-bit value and carries an overflow flag. It is then gated by a per-channel charge threshold. A result that passes is offered on a valid/ready output as one record: start time, charge, overflow flag and pileup index. Back-pressure works as follows. While a record is valid and not accepted, it is held unchanged and the sample input deasserts its ready, so no sample is consumed until the record is taken. A record and a sample may both be accepted in the same cycle.

Sample positions count from the beat that carries `win_first` (position 0). The integral window covers positions `iw_start` up to, but not including, `iw_start + iw_len`. The user must keep `iw_start >= 4` and `iw_start + iw_len + 4` within the search window length.

Top module: `pulse_charge_integrator`

## Requirements
- R1: After reset `res_valid` is 0 and `smp_ready` is 1.
- R2: A beat with `pulse_start` high, no integral open and position inside the integral window opens an integral. The integral holds that beat's `smp_data - baseline` and captures `start_time`. Each later beat that does not close it adds its difference.
- R3: While an integral is open and its peak difference is above zero, a beat whose difference times 32 is at most the peak closes the integral. That beat's sample is not added.
- R4: A beat at a position outside `[iw_start, iw_start+iw_len)` closes an open integral without adding its sample. The beat carrying `win_first` is position 0, and each later beat adds one.
- R5: A beat with `pileup_min` high closes the open integral, unless R4 or R6 closes it first. It then opens a new integral from that beat's difference, captures that beat's `start_time` and raises the pileup index by one (saturating at 3). This condition takes priority over R3.
- R6: An integral holds at most `max_len` samples. The next beat closes it without being added. A `max_len` of 0 acts as 1023.
- R7: With `q_thr` equal to 0, every closed integral is emitted, negative ones included. Otherwise only integrals whose clamped charge is at least `q_thr` are emitted, and the rest are dropped.
- R8: `res_charge` is the sum clamped to the range -32768..32767. `res_ovf` is 1 if the sum was clamped or if any added sample was 0x000 or 0xFFF.
- R9: While `res_valid` is high and `res_ready` low, every record field stays stable and `smp_ready` is 0.
- R10: `pulse_start` on a beat outside the integral window, or while an integral is open, has no effect.
- R11: The first integral opened by `pulse_start` has `res_idx` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample beat offered |
| smp_ready | output | 1 | Sample beat can be taken |
| smp_data | input | 12 | Unsigned ADC sample |
| baseline | input | 12 | Current baseline of the channel |
| win_first | input | 1 | This beat is position 0 of the search window |
| pulse_start | input | 1 | Upstream pulse-start strobe for this beat |
| pileup_min | input | 1 | Upstream inter-pulse minimum strobe for this beat |
| start_time | input | 16 | Start time to record with an integral opened on this beat |
| iw_start | input | 10 | Integral window start position |
| iw_len | input | 10 | Integral window length in samples |
| max_len | input | 10 | Integration length cap, 0 means 1023 |
| q_thr | input | 15 | Charge threshold, 0 passes all |
| res_valid | output | 1 | Record offered |
| res_ready | input | 1 | Record accepted |
| res_time | output | 16 | Start time of the integral |
| res_charge | output | 16 | Signed clamped charge |
| res_ovf | output | 1 | Clamp or saturated sample flag |
| res_idx | output | 2 | Pileup index within the pulse train |

## Verification
A wrong open/closed state or a wrong position count shows up at the ports as a record that comes one or more beats early or late. Because the pulses in the test carry a fixed difference per sample, such a record has a charge off by whole multiples of that amplitude. It also shows up as a missing record or an extra one. A stale peak or a wrong pileup index changes the charge or `res_idx` of the very next record. Faulty hold logic shows within one cycle of back-pressure, as a changing record or a `smp_ready` that stays high.

// File: rtl/pci_pkg.sv
package pci_pkg;
  localparam int SMP_W = 12;
  localparam int ACC_W = 24;
  localparam int OUT_W = 16;
  localparam int POS_W = 11;
  localparam int LEN_W = 10;
  localparam int TIM_W = 16;
  localparam int IDX_W = 2;

  typedef struct packed {
    logic [TIM_W-1:0]        tstamp;
    logic signed [OUT_W-1:0] charge;
    logic                    ovf;
    logic [IDX_W-1:0]        idx;
  } pci_rec_t;
endpackage

// File: rtl/pci_window.sv
module pci_window #(
  parameter int POS_W = 11,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             win_first,
  input  logic [LEN_W-1:0] iw_start,
  input  logic [LEN_W-1:0] iw_len,
  output logic             in_win
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q, cur_pos, win_end;

  always_comb begin
    if (win_first)             cur_pos = '0;
    else if (pos_q == POS_MAX) cur_pos = pos_q;
    else                       cur_pos = pos_q + 1'b1;
    win_end = POS_W'(iw_start) + POS_W'(iw_len);
    in_win  = (cur_pos >= POS_W'(iw_start)) && (cur_pos < win_end);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pos_q <= POS_MAX;
    else if (beat) pos_q <= cur_pos;
  end

  assert_pos_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat && win_first |=> pos_q == '0);
endmodule

// File: rtl/pci_accum.sv
module pci_accum #(
  parameter int DIF_W = 13,
  parameter int ACC_W = 24,
  parameter int LEN_W = 10,
  parameter int TIM_W = 16,
  parameter int IDX_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic                    in_win,
  input  logic signed [DIF_W-1:0] diff,
  input  logic                    smp_clip,
  input  logic                    pulse_start,
  input  logic                    pileup_min,
  input  logic [TIM_W-1:0]        start_time,
  input  logic [LEN_W-1:0]        max_len,
  output logic                    close_v,
  output logic signed [ACC_W-1:0] acc_q,
  output logic                    clip_q,
  output logic [TIM_W-1:0]        time_q,
  output logic [IDX_W-1:0]        idx_q
);
  localparam int CMP_W = DIF_W + 5;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic                    act_q;
  logic signed [DIF_W-1:0] peak_q;
  logic [LEN_W-1:0]        len_q, max_eff;
  logic signed [CMP_W-1:0] diff_x32;
  logic fall, end_hard, open_new, restart;

  always_comb begin
    max_eff  = (max_len == '0) ? '1 : max_len;
    diff_x32 = CMP_W'(diff) <<< 5;
    fall     = (peak_q > 0) && (diff_x32 <= CMP_W'(peak_q));
    end_hard = !in_win || (len_q == max_eff);
    close_v  = beat && act_q && (end_hard || pileup_min || fall);
    restart  = beat && act_q && !end_hard && pileup_min;
    open_new = beat && !act_q && pulse_start && in_win;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      acc_q  <= '0;
      peak_q <= '0;
      len_q  <= '0;
      clip_q <= 1'b0;
      time_q <= '0;
      idx_q  <= '0;
    end else if (open_new || restart) begin
      act_q  <= 1'b1;
      acc_q  <= ACC_W'(diff);
      peak_q <= diff;
      len_q  <= LEN_W'(1);
      clip_q <= smp_clip;
      time_q <= start_time;
      idx_q  <= open_new ? '0 : ((idx_q == IDX_MAX) ? idx_q : idx_q + 1'b1);
    end else if (close_v) begin
      act_q <= 1'b0;
    end else if (beat && act_q) begin
      acc_q  <= acc_q + ACC_W'(diff);
      len_q  <= len_q + 1'b1;
      clip_q <= clip_q | smp_clip;
      if (diff > peak_q) peak_q <= diff;
    end
  end

  assert_window_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat && act_q && !in_win |=> !act_q);
  assert_pileup_reopen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat && act_q && in_win && (len_q != max_eff) && pileup_min |=> act_q && idx_q != '0);
endmodule

// File: rtl/pci_result.sv
module pci_result
  import pci_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int THR_W = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    close_v,
  input  logic signed [ACC_W-1:0] acc,
  input  logic                    clip,
  input  logic [TIM_W-1:0]        tstamp,
  input  logic [IDX_W-1:0]        idx,
  input  logic [THR_W-1:0]        q_thr,
  input  logic                    res_ready,
  output logic                    res_valid,
  output pci_rec_t                rec_q
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'(32767);
  localparam logic signed [ACC_W-1:0] LO = -ACC_W'(32768);

  logic signed [OUT_W-1:0] charge;
  logic hi_clamp, lo_clamp, emit;

  always_comb begin
    hi_clamp = acc > HI;
    lo_clamp = acc < LO;
    if (hi_clamp)      charge = 16'sh7FFF;
    else if (lo_clamp) charge = 16'sh8000;
    else               charge = OUT_W'(acc);
    emit = close_v && ((q_thr == '0) || (charge >= $signed({1'b0, q_thr})));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      rec_q     <= '0;
    end else if (emit) begin
      res_valid    <= 1'b1;
      rec_q.tstamp <= tstamp;
      rec_q.charge <= charge;
      rec_q.ovf    <= hi_clamp | lo_clamp | clip;
      rec_q.idx    <= idx;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(rec_q));
  assert_thr_positive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    emit && q_thr != '0 |=> rec_q.charge > 0);
endmodule

// File: rtl/pulse_charge_integrator.sv
module pulse_charge_integrator
  import pci_pkg::*;
#(
  parameter int THR_W = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [SMP_W-1:0]        smp_data,
  input  logic [SMP_W-1:0]        baseline,
  input  logic                    win_first,
  input  logic                    pulse_start,
  input  logic                    pileup_min,
  input  logic [TIM_W-1:0]        start_time,
  input  logic [LEN_W-1:0]        iw_start,
  input  logic [LEN_W-1:0]        iw_len,
  input  logic [LEN_W-1:0]        max_len,
  input  logic [THR_W-1:0]        q_thr,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [TIM_W-1:0]        res_time,
  output logic signed [OUT_W-1:0] res_charge,
  output logic                    res_ovf,
  output logic [IDX_W-1:0]        res_idx
);
  localparam int DIF_W = SMP_W + 1;
  localparam logic [SMP_W-1:0] FULL = '1;

  logic beat, in_win, smp_clip, close_v, clip_q;
  logic signed [DIF_W-1:0] diff;
  logic signed [ACC_W-1:0] acc_q;
  logic [TIM_W-1:0] time_q;
  logic [IDX_W-1:0] idx_q;
  pci_rec_t rec_q;

  assign smp_ready = !res_valid || res_ready;
  assign beat      = smp_valid && smp_ready;
  assign diff      = $signed({1'b0, smp_data}) - $signed({1'b0, baseline});
  assign smp_clip  = (smp_data == '0) || (smp_data == FULL);

  pci_window #(.POS_W(POS_W), .LEN_W(LEN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .beat(beat), .win_first(win_first),
    .iw_start(iw_start), .iw_len(iw_len), .in_win(in_win));

  pci_accum #(.DIF_W(DIF_W), .ACC_W(ACC_W), .LEN_W(LEN_W), .TIM_W(TIM_W),
              .IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .beat(beat), .in_win(in_win), .diff(diff),
    .smp_clip(smp_clip), .pulse_start(pulse_start), .pileup_min(pileup_min),
    .start_time(start_time), .max_len(max_len), .close_v(close_v),
    .acc_q(acc_q), .clip_q(clip_q), .time_q(time_q), .idx_q(idx_q));

  pci_result #(.ACC_W(ACC_W), .THR_W(THR_W)) u_res (
    .clk(clk), .rst_n(rst_n), .close_v(close_v), .acc(acc_q), .clip(clip_q),
    .tstamp(time_q), .idx(idx_q), .q_thr(q_thr), .res_ready(res_ready),
    .res_valid(res_valid), .rec_q(rec_q));

  assign res_time   = rec_q.tstamp;
  assign res_charge = rec_q.charge;
  assign res_ovf    = rec_q.ovf;
  assign res_idx    = rec_q.idx;

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !smp_ready);
endmodule

// File: tb/pulse_charge_integrator_tb.sv
module pulse_charge_integrator_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0, win_first = 1'b0, pulse_start = 1'b0, pileup_min = 1'b0;
  logic [11:0] smp_data = '0, baseline = '0;
  logic [15:0] start_time = '0;
  logic [9:0] iw_start = 10'd4, iw_len = 10'd30, max_len = '0;
  logic [14:0] q_thr = '0;
  logic res_ready = 1'b1;
  logic smp_ready, res_valid, res_ovf;
  logic [15:0] res_time;
  logic signed [15:0] res_charge;
  logic [1:0] res_idx;

  always #5 clk = ~clk;

  pulse_charge_integrator u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .baseline(baseline), .win_first(win_first),
    .pulse_start(pulse_start), .pileup_min(pileup_min), .start_time(start_time),
    .iw_start(iw_start), .iw_len(iw_len), .max_len(max_len), .q_thr(q_thr),
    .res_valid(res_valid), .res_ready(res_ready), .res_time(res_time),
    .res_charge(res_charge), .res_ovf(res_ovf), .res_idx(res_idx));

  int checks = 0, fails = 0, nrec = 0;
  int r_charge [32];
  int r_time [32];
  int r_ovf [32];
  int r_idx [32];

  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready && nrec < 32) begin
      r_charge[nrec] = int'(res_charge);
      r_time[nrec]   = int'(res_time);
      r_ovf[nrec]    = int'(res_ovf);
      r_idx[nrec]    = int'(res_idx);
      nrec++;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic beat(input int data, input bit first, input bit ps, input bit pm, input int st);
    smp_data = 12'(data); win_first = first; pulse_start = ps; pileup_min = pm;
    start_time = 16'(st); smp_valid = 1'b1;
    while (!smp_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0; pulse_start = 1'b0; pileup_min = 1'b0; win_first = 1'b0;
  endtask

  task automatic run_pulse(input int base, input int amp, input int plen, input int ppos, input int st);
    baseline = 12'(base);
    for (int p = 0; p < 45; p++)
      beat((p >= ppos && p < ppos + plen) ? base + amp : base, p == 0, p == ppos, 1'b0, st);
  endtask

  typedef struct packed {
    logic [11:0]        base;
    logic signed [12:0] amp;
    logic [9:0]         plen;
    logic [9:0]         iwl;
    logic [9:0]         maxl;
    logic [14:0]        thr;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{12'd100,  13'sd50,  10'd8,  10'd30, 10'd0, 15'd0},   // R2 R3 fall stop
    '{12'd2000, 13'sd300, 10'd20, 10'd10, 10'd0, 15'd0},   // R4 window end
    '{12'd50,   13'sd40,  10'd20, 10'd30, 10'd6, 15'd0},   // R6 cap
    '{12'd1000, -13'sd30, 10'd5,  10'd30, 10'd0, 15'd0},   // R7 negative passes
    '{12'd1000, -13'sd30, 10'd5,  10'd30, 10'd0, 15'd10},  // R7 negative dropped
    '{12'd100,  13'sd20,  10'd4,  10'd30, 10'd0, 15'd100}, // R7 below threshold
    '{12'd100,  13'sd20,  10'd5,  10'd30, 10'd0, 15'd100}  // R7 at threshold
  };

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    int n0, n, ch, meff, amp;
    bit em;
    repeat (3) @(negedge clk);
    check("R1 res_valid", int'(res_valid), 0);
    check("R1 smp_ready", int'(smp_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VT[i]) begin
      iw_len = VT[i].iwl; max_len = VT[i].maxl; q_thr = VT[i].thr;
      amp = int'(VT[i].amp);
      n0 = nrec;
      run_pulse(int'(VT[i].base), amp, int'(VT[i].plen), 5, 16'h1000 + i);
      meff = (VT[i].maxl == 0) ? 1023 : int'(VT[i].maxl);
      n = int'(VT[i].plen);
      if (int'(VT[i].iwl) - 1 < n) n = int'(VT[i].iwl) - 1;
      if (meff < n) n = meff;
      ch = amp * n;
      em = (VT[i].thr == 0) || (ch >= int'(VT[i].thr));
      check($sformatf("R7 vector %0d record count", i), nrec - n0, em ? 1 : 0);
      if (em && nrec > n0) begin
        check($sformatf("R2 vector %0d charge", i), r_charge[n0], ch);
        check($sformatf("R2 vector %0d time", i), r_time[n0], 16'h1000 + i);
        check($sformatf("R11 vector %0d idx", i), r_idx[n0], 0);
        check($sformatf("R8 vector %0d ovf", i), r_ovf[n0], 0);
      end
    end

    // R5 pileup: 5 samples at +60, minimum at pos 10, then 5 samples at +10
    iw_len = 10'd30; max_len = '0; q_thr = '0; baseline = 12'd100;
    n0 = nrec;
    for (int p = 0; p < 45; p++)
      beat((p >= 5 && p < 10) ? 160 : ((p >= 10 && p < 15) ? 110 : 100),
           p == 0, p == 5, p == 10, (p == 10) ? 16'h2222 : 16'h1234);
    check("R5 pileup record count", nrec - n0, 2);
    check("R5 first charge", r_charge[n0], 300);
    check("R5 first idx", r_idx[n0], 0);
    check("R5 second charge", r_charge[n0+1], 50);
    check("R5 second idx", r_idx[n0+1], 1);
    check("R5 second time", r_time[n0+1], 16'h2222);

    // R8 accumulator clamp
    iw_len = 10'd40; n0 = nrec;
    run_pulse(0, 4095, 30, 5, 7);
    check("R8 clamp count", nrec - n0, 1);
    check("R8 clamp charge", r_charge[n0], 32767);
    check("R8 clamp ovf", r_ovf[n0], 1);

    // R8 saturated sample code without clamp
    n0 = nrec;
    run_pulse(100, 3995, 2, 5, 8);
    check("R8 sample code charge", r_charge[n0], 7990);
    check("R8 sample code ovf", r_ovf[n0], 1);

    // R10 start strobe before the integral window
    n0 = nrec;
    run_pulse(100, 50, 6, 2, 9);
    check("R10 ignored start count", nrec - n0, 0);

    // R9 back-pressure hold
    iw_len = 10'd30; baseline = 12'd100; res_ready = 1'b0; n0 = nrec;
    for (int p = 0; p < 14; p++)
      beat((p >= 5 && p < 13) ? 150 : 100, p == 0, p == 5, 1'b0, 16'h0777);
    repeat (3) @(negedge clk);
    check("R9 held valid", int'(res_valid), 1);
    check("R9 stall ready", int'(smp_ready), 0);
    check("R9 held charge", int'(res_charge), 400);
    check("R9 held time", int'(res_time), 16'h0777);
    res_ready = 1'b1;
    @(negedge clk);
    check("R9 released count", nrec - n0, 1);
    check("R9 ready restored", int'(smp_ready), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule